// File: doc/BRIEF.md
# Multi-Mode Interval Timer Channel Group

This block is a group of down-counting interval timer channels (three by default) that share one counter clock enable. Each channel holds a loaded count N and an operating mode, counts the enable ticks that have elapsed since the load, and shapes a single output line from that elapsed count. The six modes are: terminal-count flag, one-shot low pulse, periodic rate pulse, square wave, and two single-tick strobes. Each channel also reports its elapsed count.

A channel is driven by a load strobe that samples a shared 16-bit count value and a 3-bit mode value. It also has a gate that a per-channel write strobe sets. While the gate is low, the gate freezes the periodic modes. Each channel is a small sequencer with four named states. ST_LOADED means no tick has been counted since the load. ST_RUN means counting, before terminal count in one-shot modes and indefinitely in periodic modes. ST_AT_TC means the elapsed count equals N. ST_PAST means the elapsed count is beyond N.

The sequencer has these transitions:
- A load enters ST_LOADED from any state.
- The first counted tick leaves ST_LOADED for ST_RUN. In a one-shot mode with N=1 it goes to ST_AT_TC instead.
- ST_RUN goes to ST_AT_TC on the tick that makes the elapsed count equal N (one-shot modes).
- ST_AT_TC goes to ST_PAST on the next counted tick.
- ST_PAST holds until the next load.
- In periodic modes, ST_RUN stays in ST_RUN, and its phase wraps to zero every N ticks.

Top module: `itv_timer3`

## Requirements
- R1: A load strobe takes effect at the clock edge where it is sampled. N becomes the count value, and a count value of 0 means 65536. The mode is sampled at the same edge. The elapsed count d becomes 0. A tick in the same cycle is not counted.
- R2: d advances by one at each edge where tick is high and the channel is not gated. With tick low, elapsed output and line hold.
- R3: Mode 0 (mode value 3'd0): the output is low while d < N and high once d >= N. It stays high until the next load.
- R4: Mode 1 (3'd1): the output is high while d < N and low once d >= N.
- R5: Mode 2 (3'd2): the output is high only while d is a nonzero multiple of N, which gives a one-tick pulse every N ticks.
- R6: Mode 3 (3'd3): the output is high while (d mod N) < (N+1)/2 (integer division) and low otherwise. With an odd N the high part is one tick longer.
- R7: Modes 4 and 5 (3'd4, 3'd5): the output is high only while d equals N.
- R8: Mode values 3'd6 and 3'd7 behave exactly as mode 0.
- R9: In modes 2 and 3 a low gate freezes d and forces the output high. In the other modes the gate has no effect.
- R10: The elapsed output is d mod N in modes 2 and 3. In the other modes it is d capped at N.
- R11: After reset every channel is in mode 3 with N=65536 and d=0. The gate is 1 for channels 0 and 1 and 0 for channel 2.
- R12: gate_we[i] loads gate_val into the gate of channel i only. Loads, gate writes and counting in one channel leave the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter clock enable shared by all channels |
| load_sel | input | NCH | Per-channel load strobe |
| cnt_val | input | CNT_W | Count value sampled on load (0 means 2^CNT_W) |
| mode_val | input | 3 | Mode value sampled on load |
| gate_we | input | NCH | Per-channel gate write strobe |
| gate_val | input | 1 | Gate value written by gate_we |
| tmr_out | output | NCH | Output line of each channel |
| elapsed | output | NCH x (CNT_W+1) | Elapsed count of each channel |

## Verification
Every mode is driven with an odd N (5) and an even N (6), and the tick stream has gaps. The odd and even values expose an asymmetric square-wave half or a misplaced pulse. The gaps separate counting of ticks from counting of clocks. N=1 is run in the one-shot, strobe and periodic modes to exercise the immediate-terminal path of the sequencer. A count of 0 distinguishes 65536 from zero. A load that coincides with a tick shows whether that tick is wrongly counted. Gate toggles in periodic and non-periodic modes separate freezing from ignoring the gate. All channels are compared against the bench model on every cycle, so any disturbance of a neighbouring channel is caught.

// File: rtl/itv_pkg.sv
package itv_pkg;

    typedef enum logic [1:0] {
        ST_LOADED = 2'd0,
        ST_RUN    = 2'd1,
        ST_AT_TC  = 2'd2,
        ST_PAST   = 2'd3
    } seq_state_e;

    typedef enum logic [2:0] {
        MD_TC_FLAG  = 3'd0,
        MD_ONE_SHOT = 3'd1,
        MD_RATE     = 3'd2,
        MD_SQUARE   = 3'd3,
        MD_STROBE_A = 3'd4,
        MD_STROBE_B = 3'd5
    } mode_e;

    // undefined mode values fall back to the terminal-count flag mode
    function automatic mode_e fold_mode(input logic [2:0] raw);
        if (raw > 3'd5) return MD_TC_FLAG;
        return mode_e'(raw);
    endfunction

    function automatic logic is_periodic(input mode_e m);
        return (m == MD_RATE) || (m == MD_SQUARE);
    endfunction

    function automatic logic is_strobe(input mode_e m);
        return (m == MD_STROBE_A) || (m == MD_STROBE_B);
    endfunction

endpackage

// File: rtl/itv_seq.sv
module itv_seq
    import itv_pkg::*;
#(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic          periodic,
    input  logic [CW-1:0] n_cur,
    output seq_state_e    st,
    output logic [CW-1:0] ph
);

    seq_state_e    st_n;
    logic [CW-1:0] ph_n;
    logic [CW-1:0] ph_inc;
    logic          wrap;

    assign ph_inc = ph + 1'b1;
    assign wrap   = (ph_inc == n_cur);

    always_comb begin
        st_n = st;
        ph_n = ph;
        if (load) begin
            st_n = ST_LOADED;
            ph_n = '0;
        end else if (adv) begin
            unique case (st)
                ST_LOADED, ST_RUN: begin
                    if (periodic) begin
                        st_n = ST_RUN;
                        ph_n = wrap ? '0 : ph_inc;
                    end else begin
                        ph_n = ph_inc;
                        st_n = wrap ? ST_AT_TC : ST_RUN;
                    end
                end
                ST_AT_TC: st_n = ST_PAST;
                ST_PAST:  st_n = ST_PAST;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_LOADED;
            ph <= '0;
        end else begin
            st <= st_n;
            ph <= ph_n;
        end
    end

    // R10: phase never exceeds the loaded count
    assert_phase_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ph <= n_cur);

    // R1: a load always restarts the sequence
    assert_load_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st == ST_LOADED) && (ph == '0));

endmodule

// File: rtl/itv_wave.sv
module itv_wave
    import itv_pkg::*;
#(
    parameter int CW = 17
) (
    input  mode_e         mode,
    input  seq_state_e    st,
    input  logic [CW-1:0] ph,
    input  logic [CW-1:0] n_cur,
    input  logic          gate,
    output logic          out
);

    logic [CW:0] half;

    assign half = ({1'b0, n_cur} + 1'b1) >> 1;

    always_comb begin
        unique case (mode)
            MD_TC_FLAG:  out = (st == ST_AT_TC) || (st == ST_PAST);
            MD_ONE_SHOT: out = (st == ST_LOADED) || (st == ST_RUN);
            MD_RATE:     out = !gate || ((st == ST_RUN) && (ph == '0));
            MD_SQUARE:   out = !gate || ({1'b0, ph} < half);
            MD_STROBE_A,
            MD_STROBE_B: out = (st == ST_AT_TC);
            default:     out = (st == ST_AT_TC) || (st == ST_PAST);
        endcase
    end

endmodule

// File: rtl/itv_channel.sv
module itv_channel
    import itv_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter bit GATE_RST = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [2:0]       mode_val,
    input  logic             gate_we,
    input  logic             gate_val,
    output logic             tmr_out,
    output logic [CNT_W:0]   elapsed
);

    localparam int            CW   = CNT_W + 1;
    localparam logic [CW-1:0] FULL = CW'(1) << CNT_W;

    logic [CW-1:0] n_q;
    mode_e         mode_q;
    logic          gate_q;
    logic          periodic;
    logic          adv;
    seq_state_e    st;
    logic [CW-1:0] ph;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q    <= FULL;
            mode_q <= MD_SQUARE;
            gate_q <= GATE_RST;
        end else begin
            if (load) begin
                n_q    <= (cnt_val == '0) ? FULL : {1'b0, cnt_val};
                mode_q <= fold_mode(mode_val);
            end
            if (gate_we) gate_q <= gate_val;
        end
    end

    assign periodic = is_periodic(mode_q);
    assign adv      = tick & (gate_q | ~periodic);

    itv_seq #(.CW(CW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .adv      (adv),
        .periodic (periodic),
        .n_cur    (n_q),
        .st       (st),
        .ph       (ph)
    );

    itv_wave #(.CW(CW)) u_wave (
        .mode  (mode_q),
        .st    (st),
        .ph    (ph),
        .n_cur (n_q),
        .gate  (gate_q),
        .out   (tmr_out)
    );

    assign elapsed = ph;

    // R2: no tick, no load -> sequence frozen
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> ($stable(ph) && $stable(st)));

    // R9: low gate freezes a periodic channel
    assert_gate_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !gate_q && periodic) |=> $stable(ph));

    // R3: terminal-count flag stays high until reload
    assert_tc_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MD_TC_FLAG && tmr_out && !load) |=> tmr_out);

    // R7: strobe lasts one counted tick
    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_strobe(mode_q) && tmr_out && tick && !load) |=> !tmr_out);

endmodule

// File: rtl/itv_timer3.sv
module itv_timer3
    import itv_pkg::*;
#(
    parameter int             NCH           = 3,
    parameter int             CNT_W         = 16,
    parameter logic [NCH-1:0] GATE_RST_MASK = 3'b011
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic [NCH-1:0]            load_sel,
    input  logic [CNT_W-1:0]          cnt_val,
    input  logic [2:0]                mode_val,
    input  logic [NCH-1:0]            gate_we,
    input  logic                      gate_val,
    output logic [NCH-1:0]            tmr_out,
    output logic [NCH-1:0][CNT_W:0]   elapsed
);

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        itv_channel #(
            .CNT_W    (CNT_W),
            .GATE_RST (GATE_RST_MASK[g])
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .load     (load_sel[g]),
            .cnt_val  (cnt_val),
            .mode_val (mode_val),
            .gate_we  (gate_we[g]),
            .gate_val (gate_val),
            .tmr_out  (tmr_out[g]),
            .elapsed  (elapsed[g])
        );
    end

endmodule

// File: tb/itv_timer3_tb.sv
module itv_timer3_tb;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick = 1'b0;
    logic [2:0]       load_sel = '0;
    logic [15:0]      cnt_val = '0;
    logic [2:0]       mode_val = '0;
    logic [2:0]       gate_we = '0;
    logic             gate_val = 1'b0;
    logic [2:0]       tmr_out;
    logic [2:0][16:0] elapsed;

    always #10 clk = ~clk;

    itv_timer3 u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load_sel (load_sel),
        .cnt_val  (cnt_val),
        .mode_val (mode_val),
        .gate_we  (gate_we),
        .gate_val (gate_val),
        .tmr_out  (tmr_out),
        .elapsed  (elapsed)
    );

    typedef struct {
        int    ch;
        bit    out;
        int    el;
        string tag;
    } exp_t;

    exp_t  q[$];
    int    checks = 0;
    int    fails = 0;
    string cur_tag = "R11";

    int m_n[3];
    int m_d[3];
    int m_mode[3];
    bit m_gate[3];

    function automatic bit m_periodic(int ch);
        return (m_mode[ch] == 2) || (m_mode[ch] == 3);
    endfunction

    function automatic bit m_out(int ch);
        int n = m_n[ch];
        int d = m_d[ch];
        case (m_mode[ch])
            0: return d >= n;
            1: return d < n;
            2: return !m_gate[ch] || (d != 0 && (d % n) == 0);
            3: return !m_gate[ch] || ((d % n) < ((n + 1) / 2));
            default: return d == n;
        endcase
    endfunction

    function automatic int m_el(int ch);
        if (m_periodic(ch)) return m_d[ch] % m_n[ch];
        return (m_d[ch] > m_n[ch]) ? m_n[ch] : m_d[ch];
    endfunction

    function automatic string mode_tag(int md);
        case (md)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4, 5: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic push_all();
        for (int ch = 0; ch < 3; ch++) begin
            exp_t e;
            e.ch = ch; e.out = m_out(ch); e.el = m_el(ch); e.tag = cur_tag;
            q.push_back(e);
        end
    endtask

    task automatic advance_model(bit tk);
        for (int ch = 0; ch < 3; ch++)
            if (tk && (m_gate[ch] || !m_periodic(ch))) m_d[ch]++;
    endtask

    task automatic step(bit tk);
        @(negedge clk);
        load_sel = '0; gate_we = '0; tick = tk;
        advance_model(tk);
        push_all();
    endtask

    task automatic run(int n, int pat);
        for (int i = 0; i < n; i++)
            step((pat == 0) ? 1'b1 : ((i % pat) != (pat - 1)));
    endtask

    // R1: load semantics in the model (zero means 65536, tick in load cycle dropped)
    task automatic load_ch(int ch, int val, int md, bit tk);
        @(negedge clk);
        gate_we = '0; tick = tk;
        load_sel = 3'(1 << ch);
        cnt_val = 16'(val);
        mode_val = 3'(md);
        advance_model(tk);
        m_n[ch] = (val == 0) ? 65536 : val;
        m_mode[ch] = (md > 5) ? 0 : md;
        m_d[ch] = 0;
        push_all();
    endtask

    task automatic set_gate(int ch, bit g, bit tk);
        @(negedge clk);
        load_sel = '0; tick = tk;
        gate_we = 3'(1 << ch);
        gate_val = g;
        advance_model(tk);
        m_gate[ch] = g;
        push_all();
    endtask

    // monitor: compare all pending expectations after each edge
    always @(posedge clk) begin
        exp_t e;
        #5;
        while (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (tmr_out[e.ch] !== e.out) begin
                fails++;
                $display("FAIL %s output ch%0d act=%0b exp=%0b", e.tag, e.ch, tmr_out[e.ch], e.out);
            end
            checks++;
            if (elapsed[e.ch] !== 17'(e.el)) begin
                fails++;
                $display("FAIL %s/R10 elapsed ch%0d act=%0d exp=%0d", e.tag, e.ch, elapsed[e.ch], e.el);
            end
        end
    end

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int ch = 0; ch < 3; ch++) begin
            m_n[ch] = 65536; m_mode[ch] = 3; m_d[ch] = 0; m_gate[ch] = (ch != 2);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset defaults, channel 2 gated off
        cur_tag = "R11";
        step(1'b0);
        run(3, 0);

        // R2: idle cycles hold
        cur_tag = "R2";
        step(1'b0); step(1'b0); step(1'b1); step(1'b0);

        // R3..R8: every mode value, odd and even N, ticks with gaps
        for (int md = 0; md < 8; md++) begin
            for (int k = 0; k < 2; k++) begin
                cur_tag = mode_tag(md);
                load_ch(0, 5 + k, md, 1'b0);
                run(3 * (5 + k) + 3, 3);
            end
        end

        // N = 1 corner
        for (int j = 0; j < 4; j++) begin
            int md;
            md = (j == 3) ? 4 : j * 1 + ((j > 0) ? 1 : 0);
            cur_tag = mode_tag(md);
            load_ch(0, 1, md, 1'b0);
            run(4, 0);
        end

        // R1: coincident tick, zero count, reload mid-count
        cur_tag = "R1";
        load_ch(0, 4, 0, 1'b1);
        run(6, 0);
        load_ch(1, 0, 1, 1'b0);
        run(40, 0);
        load_ch(1, 0, 3, 1'b0);
        run(10, 0);
        load_ch(0, 7, 3, 1'b0);
        run(4, 0);
        load_ch(0, 3, 2, 1'b0);
        run(7, 0);

        // R9: gate in periodic and one-shot modes
        cur_tag = "R9";
        load_ch(1, 5, 3, 1'b0);
        run(3, 0);
        set_gate(1, 1'b0, 1'b1);
        run(5, 0);
        set_gate(1, 1'b1, 1'b0);
        run(8, 0);
        load_ch(1, 4, 2, 1'b0);
        run(2, 0);
        set_gate(1, 1'b0, 1'b0);
        run(4, 0);
        set_gate(1, 1'b1, 1'b1);
        run(8, 0);
        load_ch(1, 3, 0, 1'b0);
        set_gate(1, 1'b0, 1'b0);
        run(5, 0);
        set_gate(1, 1'b1, 1'b0);

        // R12: per-channel gate write and independence
        cur_tag = "R12";
        set_gate(2, 1'b1, 1'b0);
        load_ch(2, 3, 2, 1'b0);
        run(8, 0);
        load_ch(0, 2, 5, 1'b1);
        run(5, 2);

        @(negedge clk);
        tick = 1'b0; load_sel = '0; gate_we = '0;
        repeat (2) @(posedge clk);
        #6;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule